// File: doc/BRIEF.md
# Element-Serial Vector Mask Merge and Test Pipeline

This block handles one vector instruction at a time, one element per clock. An instruction is started by a `start` pulse. The pulse carries its opening settings: an operation select, a test condition, a scalar-substitution flag, a 7-bit element count, a 64-bit mask and a 64-bit scalar. All of these settings are latched at that moment. The block then accepts one operand pair per clock in which `in_valid` is high, until the element count is used up.

Every accepted element produces exactly one result, three clocks after it was accepted.

- **Merge:** each result is operand A or operand B. The choice is made by the mask bit that belongs to that element. Element i is controlled by mask bit 63-i, so the most significant mask bit steers element 0.
- **Test:** each element is checked against the chosen condition. The outcome is written into a 64-bit result mask at bit 63-i. Mask bits for elements that were not processed read as zero.
- **Scalar substitution:** when selected, the latched scalar replaces operand A for every element.

Sequencing is done by a two-state controller:
- `ST_IDLE` waits for `start`.
  - On `start` with a nonzero count, it takes transition T_LAUNCH into `ST_RUN`.
  - On `start` with a count of zero, it takes transition T_EMPTY and stays in `ST_IDLE`.
- `ST_RUN` accepts elements.
  - On acceptance of the last element, it takes transition T_FINISH back to `ST_IDLE`.
  - Otherwise it takes transition T_HOLD and stays in `ST_RUN`.

A following instruction may begin in the clock right after the last element of the previous one was accepted. The pipeline drains the earlier elements undisturbed.

Top module: `vmask_merge_unit`

## Requirements
- R1: After a start with count N (1..64), exactly N elements are accepted, one for each clock in which `in_valid` is high while running. `in_valid` while idle produces no result.
- R2: A start with count 0 produces no valid result and no done pulse, and leaves `mask_out` unchanged.
- R3: `out_valid` is high exactly three clocks after each accepted element, and gaps in the input are reproduced in the output.
- R4: `out_done` is high only together with the result of the last element of an instruction.
- R5: With `op`=0 (merge), the result of element i is operand A when mask bit 63-i is 1, and operand B when it is 0. A merge does not alter `mask_out`.
- R6: With `op`=1 (test), the result data is zero. Once the last result has appeared, bit 63-i of `mask_out` holds the test outcome of element i for i < N, and all other bits are 0.
- R7: `cond`=0 tests for an element equal to zero; `cond`=1 tests for a nonzero element.
- R8: With `use_scalar`=1, the scalar latched at start stands in for operand A in every element, for both merge and test.
- R9: Operation, condition, count, mask and scalar are latched at start. A `start` pulse while running is ignored.
- R10: During and right after reset, `out_valid` and `out_done` are 0 and `mask_out` is 0.
- R11: A new instruction may start in the clock directly after the previous last element was accepted. Both instructions deliver correct results with no idle clock between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (only honoured when idle) |
| op | input | 1 | 0 = merge, 1 = test |
| cond | input | 1 | 0 = equal to zero, 1 = nonzero |
| use_scalar | input | 1 | Replace operand A with the scalar |
| vlen | input | 7 | Element count, 0..64 |
| mask_in | input | 64 | Merge mask; bit 63 steers element 0 |
| scalar_in | input | 64 | Scalar operand |
| in_valid | input | 1 | Operand pair present |
| in_a | input | 64 | Operand A stream |
| in_b | input | 64 | Operand B stream |
| out_valid | output | 1 | Result present |
| out_data | output | 64 | Result element |
| out_done | output | 1 | Result belongs to the last element |
| mask_out | output | 64 | Mask built by test instructions |

## Verification
The bench goes after the reversed mask order. A design that indexed the mask from the low end would pick the wrong operand in every asymmetric mask pattern, and would set the wrong `mask_out` bits.

It probes count boundaries: 0, 1 and the full 64. An off-by-one controller would emit an extra or missing result, or a stray done pulse.

It checks stale mask bits by following a long test with a short one. A design that only ORs new bits in would leave high-index bits set.

It also covers three ordering and timing cases:
- Back-to-back instructions, where a controller that needs an idle clock would drop the first element.
- Input gaps, which expose a latency that is not fixed.
- A `start` while running, which a careless controller would honour.

// File: rtl/vmm_pkg.sv
package vmm_pkg;
    localparam int ELEM_W  = 64;
    localparam int MAX_LEN = 64;
    localparam int LEN_W   = $clog2(MAX_LEN) + 1;
    localparam int IDX_W   = $clog2(MAX_LEN);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    typedef enum logic {
        OP_MERGE = 1'b0,
        OP_TEST  = 1'b1
    } vop_t;

    typedef enum logic {
        COND_ZERO    = 1'b0,
        COND_NONZERO = 1'b1
    } vcond_t;
endpackage

// File: rtl/vmm_seq.sv
module vmm_seq
    import vmm_pkg::*;
#(
    parameter int W     = ELEM_W,
    parameter int NMAX  = MAX_LEN,
    parameter int LW    = LEN_W,
    parameter int IW    = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_in,
    input  logic          cond_in,
    input  logic          scal_in,
    input  logic [LW-1:0] vlen_in,
    input  logic [NMAX-1:0] mask_in,
    input  logic [W-1:0]  scalar_in,
    input  logic          in_valid,
    output logic          accept,
    output logic [IW-1:0] elem_idx,
    output logic          elem_first,
    output logic          elem_last,
    output vop_t          op_q,
    output vcond_t        cond_q,
    output logic          scal_q,
    output logic [NMAX-1:0] mask_q,
    output logic [W-1:0]  scalar_q
);
    seq_state_t state, state_nx;
    logic [LW-1:0] len_q;
    logic [IW-1:0] idx_q;
    logic          launch;
    logic          last_hit;

    assign launch   = (state == ST_IDLE) && start && (vlen_in != '0);
    assign last_hit = ({1'b0, idx_q} == (len_q - LW'(1)));

    // next-state: T_LAUNCH, T_EMPTY, T_HOLD, T_FINISH
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (launch) state_nx = ST_RUN;
            ST_RUN:  if (in_valid && last_hit) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            idx_q    <= '0;
            op_q     <= OP_MERGE;
            cond_q   <= COND_ZERO;
            scal_q   <= 1'b0;
            mask_q   <= '0;
            scalar_q <= '0;
        end else if (launch) begin
            len_q    <= vlen_in;
            idx_q    <= '0;
            op_q     <= vop_t'(op_in);
            cond_q   <= vcond_t'(cond_in);
            scal_q   <= scal_in;
            mask_q   <= mask_in;
            scalar_q <= scalar_in;
        end else if (accept) begin
            idx_q <= idx_q + IW'(1);
        end
    end

    // output process
    always_comb begin
        accept     = 1'b0;
        elem_idx   = idx_q;
        elem_first = 1'b0;
        elem_last  = 1'b0;
        unique case (state)
            ST_IDLE: accept = 1'b0;
            ST_RUN: begin
                accept     = in_valid;
                elem_first = (idx_q == '0);
                elem_last  = last_hit;
            end
            default: accept = 1'b0;
        endcase
    end

    AST_IDX_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> ({1'b0, idx_q} < len_q)); // R1
    AST_EMPTY_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && vlen_in == '0) |=> (state == ST_IDLE)); // R2
    AST_START_IGNORED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !accept) |=> ($stable(op_q) && $stable(len_q) && $stable(mask_q))); // R9
endmodule

// File: rtl/vmm_datapath.sv
module vmm_datapath
    import vmm_pkg::*;
#(
    parameter int W    = ELEM_W,
    parameter int NMAX = MAX_LEN,
    parameter int IW   = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [IW-1:0] elem_idx,
    input  logic          elem_first,
    input  logic          elem_last,
    input  vop_t          op_q,
    input  vcond_t        cond_q,
    input  logic          scal_q,
    input  logic [NMAX-1:0] mask_q,
    input  logic [W-1:0]  scalar_q,
    input  logic [W-1:0]  in_a,
    input  logic [W-1:0]  in_b,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic          out_done,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic          wr_bit,
    output logic          wr_first
);
    localparam logic [IW-1:0] TOP_IDX = IW'(NMAX - 1);

    // stage 1: capture
    logic          s1_v, s1_first, s1_last, s1_mbit;
    vop_t          s1_op;
    vcond_t        s1_cond;
    logic [IW-1:0] s1_idx;
    logic [W-1:0]  s1_a, s1_b;
    // stage 2: compute
    logic          s2_v, s2_first, s2_last, s2_tbit;
    vop_t          s2_op;
    logic [IW-1:0] s2_idx;
    logic [W-1:0]  s2_res;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0; s1_first <= 1'b0; s1_last <= 1'b0; s1_mbit <= 1'b0;
            s1_op <= OP_MERGE; s1_cond <= COND_ZERO; s1_idx <= '0;
            s1_a <= '0; s1_b <= '0;
        end else begin
            s1_v     <= accept;
            s1_first <= accept && elem_first;
            s1_last  <= accept && elem_last;
            s1_mbit  <= mask_q[TOP_IDX - elem_idx];
            s1_op    <= op_q;
            s1_cond  <= cond_q;
            s1_idx   <= elem_idx;
            s1_a     <= scal_q ? scalar_q : in_a;
            s1_b     <= in_b;
        end
    end

    logic [W-1:0] res_c;
    logic         tbit_c;
    always_comb begin
        unique case (s1_cond)
            COND_ZERO:    tbit_c = (s1_a == '0);
            COND_NONZERO: tbit_c = (s1_a != '0);
            default:      tbit_c = 1'b0;
        endcase
        unique case (s1_op)
            OP_MERGE: res_c = s1_mbit ? s1_a : s1_b;
            OP_TEST:  res_c = '0;
            default:  res_c = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v <= 1'b0; s2_first <= 1'b0; s2_last <= 1'b0; s2_tbit <= 1'b0;
            s2_op <= OP_MERGE; s2_idx <= '0; s2_res <= '0;
        end else begin
            s2_v     <= s1_v;
            s2_first <= s1_first;
            s2_last  <= s1_last;
            s2_tbit  <= tbit_c;
            s2_op    <= s1_op;
            s2_idx   <= s1_idx;
            s2_res   <= res_c;
        end
    end

    // stage 3: output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_done  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s2_v;
            out_done  <= s2_v && s2_last;
            out_data  <= s2_res;
        end
    end

    assign wr_en    = s2_v && (s2_op == OP_TEST);
    assign wr_idx   = s2_idx;
    assign wr_bit   = s2_tbit;
    assign wr_first = s2_first;

    AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> out_valid); // R4
    AST_TEST_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_v && s2_op == OP_TEST) |=> (out_data == '0)); // R6
endmodule

// File: rtl/vmm_mask_acc.sv
module vmm_mask_acc
    import vmm_pkg::*;
#(
    parameter int NMAX = MAX_LEN,
    parameter int IW   = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_bit,
    input  logic          wr_first,
    output logic [NMAX-1:0] mask_out
);
    localparam logic [IW-1:0] TOP_IDX = IW'(NMAX - 1);

    for (genvar g = 0; g < NMAX; g++) begin : g_bit
        logic hit;
        assign hit = (TOP_IDX - wr_idx) == IW'(g);
        always_ff @(posedge clk) begin
            if (!rst_n)                  mask_out[g] <= 1'b0;
            else if (wr_en && hit)       mask_out[g] <= wr_bit;
            else if (wr_en && wr_first)  mask_out[g] <= 1'b0;
        end
    end

    AST_FIRST_CLEARS_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_first) |=> ($countones(mask_out) <= 1)); // R6
    AST_MASK_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_out)); // R5
endmodule

// File: rtl/vmask_merge_unit.sv
module vmask_merge_unit
    import vmm_pkg::*;
#(
    parameter int W    = ELEM_W,
    parameter int NMAX = MAX_LEN,
    parameter int LW   = LEN_W,
    parameter int IW   = IDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            op,
    input  logic            cond,
    input  logic            use_scalar,
    input  logic [LW-1:0]   vlen,
    input  logic [NMAX-1:0] mask_in,
    input  logic [W-1:0]    scalar_in,
    input  logic            in_valid,
    input  logic [W-1:0]    in_a,
    input  logic [W-1:0]    in_b,
    output logic            out_valid,
    output logic [W-1:0]    out_data,
    output logic            out_done,
    output logic [NMAX-1:0] mask_out
);
    logic            accept, elem_first, elem_last, scal_q;
    logic [IW-1:0]   elem_idx;
    vop_t            op_q;
    vcond_t          cond_q;
    logic [NMAX-1:0] mask_q;
    logic [W-1:0]    scalar_q;
    logic            wr_en, wr_bit, wr_first;
    logic [IW-1:0]   wr_idx;

    vmm_seq #(.W(W), .NMAX(NMAX), .LW(LW), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_in(op), .cond_in(cond),
        .scal_in(use_scalar), .vlen_in(vlen), .mask_in(mask_in),
        .scalar_in(scalar_in), .in_valid(in_valid), .accept(accept),
        .elem_idx(elem_idx), .elem_first(elem_first), .elem_last(elem_last),
        .op_q(op_q), .cond_q(cond_q), .scal_q(scal_q), .mask_q(mask_q),
        .scalar_q(scalar_q)
    );

    vmm_datapath #(.W(W), .NMAX(NMAX), .IW(IW)) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .elem_idx(elem_idx),
        .elem_first(elem_first), .elem_last(elem_last), .op_q(op_q),
        .cond_q(cond_q), .scal_q(scal_q), .mask_q(mask_q), .scalar_q(scalar_q),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data),
        .out_done(out_done), .wr_en(wr_en), .wr_idx(wr_idx), .wr_bit(wr_bit),
        .wr_first(wr_first)
    );

    vmm_mask_acc #(.NMAX(NMAX), .IW(IW)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_bit(wr_bit), .wr_first(wr_first), .mask_out(mask_out)
    );

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(accept, 3)); // R3
    AST_IDLE_INPUT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !accept) |-> ##3 (out_valid == 1'b0)); // R1
endmodule

// File: tb/vmask_merge_unit_tb.sv
module vmask_merge_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;

    // vector table: op, cond, use_scalar, gap, vlen, mask, scalar
    localparam bit [0:NV-1] T_OP   = 6'b001101;
    localparam bit [0:NV-1] T_COND = 6'b000101;
    localparam bit [0:NV-1] T_SCAL = 6'b010001;
    localparam bit [0:NV-1] T_GAP  = 6'b000100;
    localparam logic [6:0]  T_LEN  [NV] = '{7'd64, 7'd5, 7'd64, 7'd10, 7'd1, 7'd7};
    localparam logic [63:0] T_MASK [NV] = '{64'hF0F0_1234_8000_0001, 64'hA800_0000_0000_0000,
                                           64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
                                           64'h8000_0000_0000_0000, 64'h0};
    localparam logic [63:0] T_SCALAR [NV] = '{64'h0, 64'hDEAD_BEEF_0000_0001, 64'h0, 64'h0,
                                             64'h0, 64'h0000_0000_0000_0005};

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, op = 1'b0, cond = 1'b0, use_scalar = 1'b0, in_valid = 1'b0;
    logic [6:0]  vlen = '0;
    logic [63:0] mask_in = '0, scalar_in = '0, in_a = '0, in_b = '0;
    logic        out_valid, out_done;
    logic [63:0] out_data, mask_out;

    int checks = 0, fails = 0, cyc = 0;
    logic [63:0] exp_data [0:1023];
    logic        exp_done [0:1023];
    int          exp_cyc  [0:1023];
    int          wr = 0, rd = 0;
    logic [63:0] exp_mask = '0;

    vmask_merge_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond(cond),
        .use_scalar(use_scalar), .vlen(vlen), .mask_in(mask_in),
        .scalar_in(scalar_in), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_data(out_data), .out_done(out_done),
        .mask_out(mask_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] elem_a(input int seed, input int i);
        if (i % 4 == 1) return 64'h0;
        return {32'h8000_0000 | 32'(seed), 32'(i * 257)};
    endfunction
    function automatic logic [63:0] elem_b(input int seed, input int i);
        return {32'(seed + 7), 32'h5A5A_0000 | 32'(i)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // result monitor: R1 R3 R4 R5 R6
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (rd >= wr) begin
                    check(1'b0, "R1 unexpected result", out_data, 64'h0);
                end else begin
                    check(exp_cyc[rd] == cyc, "R3 latency", 64'(cyc), 64'(exp_cyc[rd]));
                    check(out_data == exp_data[rd], "R5/R6/R8 data", out_data, exp_data[rd]);
                    check(out_done == exp_done[rd], "R4 done", 64'(out_done), 64'(exp_done[rd]));
                    rd++;
                end
            end else begin
                if (out_done) check(1'b0, "R4 stray done", 64'(out_done), 64'h0);
                if (rd < wr && exp_cyc[rd] <= cyc) begin
                    check(1'b0, "R3 missing result", 64'h0, exp_data[rd]);
                    rd++;
                end
            end
        end
    end

    task automatic run_instr(input bit iop, input bit icond, input bit iscal,
                             input logic [6:0] ilen, input logic [63:0] imask,
                             input logic [63:0] iscalar, input int seed,
                             input bit gap, input bit mid_start);
        logic [63:0] a, m;
        m = '0;
        start = 1'b1; op = iop; cond = icond; use_scalar = iscal;
        vlen = ilen; mask_in = imask; scalar_in = iscalar;
        tick();
        start = 1'b0;
        for (int i = 0; i < int'(ilen); i++) begin
            in_valid = 1'b1;
            in_a = elem_a(seed, i);
            in_b = elem_b(seed, i);
            a = iscal ? iscalar : in_a;
            if (mid_start && i == 2) begin   // R9: start while running
                start = 1'b1; op = ~iop; vlen = 7'd2; mask_in = ~imask;
                scalar_in = ~iscalar;
            end
            if (iop) begin
                exp_data[wr] = 64'h0;
                m[63-i] = icond ? (a != 0) : (a == 0);
            end else begin
                exp_data[wr] = imask[63-i] ? a : in_b;
            end
            exp_done[wr] = (i == int'(ilen) - 1);
            exp_cyc[wr]  = cyc + 3;
            wr++;
            tick();
            start = 1'b0;
            if (gap && (i % 2 == 1)) begin
                in_valid = 1'b0;
                tick();
            end
        end
        in_valid = 1'b0;
        if (iop && ilen != 0) exp_mask = m;
    endtask

    task automatic drain_and_check_mask(input string req);
        for (int k = 0; k < 5; k++) tick();
        check(mask_out == exp_mask, req, mask_out, exp_mask);
        check(rd == wr, "R1 result count", 64'(rd), 64'(wr));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog", 64'(cyc), 64'h0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (4) tick();
        check(out_valid == 1'b0, "R10 out_valid in reset", 64'(out_valid), 64'h0);
        check(out_done == 1'b0, "R10 out_done in reset", 64'(out_done), 64'h0);
        check(mask_out == '0, "R10 mask_out in reset", mask_out, 64'h0);
        rst_n = 1'b1;
        tick();
        check(out_valid == 1'b0, "R10 out_valid after reset", 64'(out_valid), 64'h0);

        // R1: in_valid while idle is dropped (monitor flags any result)
        in_valid = 1'b1; in_a = 64'h1; in_b = 64'h2;
        repeat (3) tick();
        in_valid = 1'b0;
        drain_and_check_mask("R1 idle input");

        // table walk: R5 R6 R7 R8 R3
        for (int v = 0; v < NV; v++) begin
            run_instr(T_OP[v], T_COND[v], T_SCAL[v], T_LEN[v], T_MASK[v],
                      T_SCALAR[v], v + 3, T_GAP[v], 1'b0);
            drain_and_check_mask("R6 mask after vector");
        end

        // R2: zero count, then inputs that must be ignored
        start = 1'b1; op = 1'b1; cond = 1'b0; vlen = 7'd0;
        tick();
        start = 1'b0;
        in_valid = 1'b1;
        repeat (3) tick();
        in_valid = 1'b0;
        drain_and_check_mask("R2 zero count keeps mask");

        // R6: long test followed by short test clears stale bits
        run_instr(1'b1, 1'b1, 1'b0, 7'd64, 64'h0, 64'h0, 11, 1'b0, 1'b0);
        drain_and_check_mask("R6 long test mask");
        run_instr(1'b1, 1'b0, 1'b0, 7'd3, 64'h0, 64'h0, 12, 1'b0, 1'b0);
        drain_and_check_mask("R6 short test clears rest");

        // R9: start while running is ignored
        run_instr(1'b0, 1'b0, 1'b0, 7'd6, 64'h5400_0000_0000_0000, 64'h0, 13, 1'b0, 1'b1);
        drain_and_check_mask("R9 mid start ignored");

        // R11: back-to-back instructions, no idle clock
        run_instr(1'b0, 1'b0, 1'b1, 7'd4, 64'h9000_0000_0000_0000, 64'h1234, 14, 1'b0, 1'b0);
        run_instr(1'b1, 1'b1, 1'b0, 7'd8, 64'h0, 64'h0, 15, 1'b0, 1'b0);
        drain_and_check_mask("R11 back-to-back mask");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule